// File: doc/BRIEF.md
# Center-Aligned PWM Time Base with Event-Driven Output Actions

This block generates two pulse-width-modulated signals from a single up-down counter. The counter climbs from zero to a programmable top value and falls back to zero, so each output edge sits symmetrically about the midpoint of the cycle. Two compare levels and the top value are written into holding registers and copied into the working registers only when the counter is at zero, so an update made in the middle of a cycle can never produce a torn pulse.

Each output has its own action table. The table maps five counter events to one of four actions: none, clear, set or toggle. The events are counter zero, compare A while rising, compare A while falling, compare B while rising and compare B while falling. With the reset tables, output A goes high at zero and low at compare A on the rising slope. Output B goes high at zero and low at compare A on the falling slope. Several copies of the block can share one time-base enable, so they stay frozen together and start in the same cycle. A sync input can reload the counter with a phase value, and a sync output either marks counter zero or repeats the sync input. An interrupt pulse marks every counter-zero event.

Top module: `pwm_updown_aq`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets `cnt_val` to 0 and drives `pwm_a`, `pwm_b`, `zero_irq` and `sync_out` low. The working top value resets to 100, both working compares reset to 50, the A table resets to 0x006 and the B table resets to 0x012.
- R2: While `tb_en` is high, the counter steps by one each clock. It rises from 0 to the top value P, shows P for one cycle and falls to 0. It shows 0 for one cycle and then rises again, so a full cycle lasts 2P clocks.
- R3: A write on `prd_wr` changes only the holding register. The counter keeps using the old top value until the first clock edge at which the counter is 0.
- R4: Writes on `cmpa_wr` and `cmpb_wr` go to holding registers. They are copied into the working compares at each clock edge where the counter is 0, whether or not `tb_en` is high.
- R5: With the reset table, `pwm_a` goes high on the edge at which the counter is 0 with `tb_en` high. It goes low on the edge at which the counter equals compare A after a rising step. Compare A on the falling slope leaves `pwm_a` unchanged.
- R6: With the reset table, `pwm_b` goes high at counter zero. It goes low on the edge at which the counter equals compare A after a falling step. Compare A on the rising slope leaves `pwm_b` unchanged.
- R7: When several events with an action other than none occur in the same cycle, the event with the highest priority decides. The order is zero first, then compare A rising, compare A falling, compare B rising and compare B falling. With compare A at 0, both outputs stay high.
- R8: While `tb_en` is low, the counter, both outputs and the interrupt hold their values. Writes are still accepted. After `tb_en` rises, counting resumes from the held value.
- R9: A write on `cnt_wr` loads `cnt_val` at the next clock edge. It takes priority over counting and over phase loading, and it works while `tb_en` is low.
- R10: When `tb_en`, `phase_en` and `sync_in` are all high, the next edge loads the counter with `phase_val` and keeps the count direction. When `phase_en` is low, `sync_in` has no effect on the count.
- R11: With `sync_master` high, `sync_out` pulses for one cycle after each counter-zero event. With `sync_master` low, `sync_out` repeats `sync_in` one clock later.
- R12: `zero_irq` is high for exactly the one cycle after each clock edge at which the counter is 0 with `tb_en` high.
- R13: `aq_wdata` carries a table in the following layout. Bits [1:0] hold the zero action, [3:2] compare A rising, [5:4] compare A falling, [7:6] compare B rising and [9:8] compare B falling. The action codes are 0 = none, 1 = clear, 2 = set and 3 = toggle. A written table takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | Shared time-base enable; counter frozen while low |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| prd_wr | input | 1 | Top-value holding register write strobe |
| prd_wdata | input | 16 | Top value |
| cmpa_wr | input | 1 | Compare A holding register write strobe |
| cmpa_wdata | input | 16 | Compare A value |
| cmpb_wr | input | 1 | Compare B holding register write strobe |
| cmpb_wdata | input | 16 | Compare B value |
| aqa_wr | input | 1 | Output A action table write strobe |
| aqb_wr | input | 1 | Output B action table write strobe |
| aq_wdata | input | 10 | Action table value |
| phase_en | input | 1 | Allows `sync_in` to reload the counter |
| phase_val | input | 16 | Value loaded on sync |
| sync_master | input | 1 | 1: `sync_out` marks zero; 0: `sync_out` repeats `sync_in` |
| sync_in | input | 1 | Sync input |
| pwm_a | output | 1 | Raw output A |
| pwm_b | output | 1 | Raw output B |
| sync_out | output | 1 | Sync output |
| zero_irq | output | 1 | One-cycle pulse per counter-zero event |
| cnt_val | output | 16 | Current counter value |

## Verification
The hardest situation to reach is a write landing in the middle of a running cycle. The old top value or compare must stay in force for the rest of that cycle, and the new one must switch in exactly at the next zero. The directed scenarios therefore issue writes and freezes from inside a cycle-accurate walk of the counter: at step 3 of a cycle for writes, and at step 5 for freezes. They then check every later step against values computed from the old parameters until the wrap, and from the new ones after it. Zero priority is exercised by placing compare A at 0, so that the falling compare event and the zero event fall on the same edge.

// File: rtl/pwmtb_pkg.sv
// Shared types for the up-down PWM time base: output action codes and
// the per-output action table layout.
package pwmtb_pkg;

    typedef enum logic [1:0] {
        AQ_NONE = 2'd0,
        AQ_CLR  = 2'd1,
        AQ_SET  = 2'd2,
        AQ_TGL  = 2'd3
    } aq_act_e;

    // Field order from MSB: compare B falling, compare B rising,
    // compare A falling, compare A rising, zero.
    typedef struct packed {
        aq_act_e cbd;
        aq_act_e cbu;
        aq_act_e cad;
        aq_act_e cau;
        aq_act_e zro;
    } aq_cfg_t;

    localparam int AQ_NEV = 5;

endpackage

// File: rtl/pwmtb_shadow.sv
// Double-buffered register: writes land in a holding copy; the working
// copy takes the holding value on every edge where 'load' is high.
// Assumes: a write and a load on the same edge copy the older holding value.
module pwmtb_shadow #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] active
);

    logic [W-1:0] held;

    // Capture software writes into the holding copy.
    always_ff @(posedge clk) begin
        if (!rst_n)  held <= RST;
        else if (wr) held <= wdata;
    end

    // Transfer the holding copy into the working copy at the load point.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= RST;
        else if (load) active <= held;
    end

    // R4 / R3: working value never moves outside a load point.
    assert_hold_between_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));

endmodule

// File: rtl/pwmtb_counter.sv
// Up-down counter of the time base. It reverses at 0 and at the working
// top value, holds while 'run' is low, and accepts direct writes and phase loads.
// Assumes: top value >= 1; a counter above the top value counts down.
module pwmtb_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_cnt,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          ld_phase,
    input  logic [CW-1:0] phase_val,
    input  logic [CW-1:0] prd_act,
    output logic [CW-1:0] cnt,
    output logic          dir_up
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    logic          step_up;
    logic [CW-1:0] cnt_nxt;

    // Choose the direction of the next step and the stepped value.
    always_comb begin
        if (cnt == ZERO)         step_up = 1'b1;
        else if (cnt >= prd_act) step_up = 1'b0;
        else                     step_up = dir_up;
        cnt_nxt = step_up ? (cnt + ONE) : (cnt - ONE);
    end

    // Advance, load or hold the counter and record the last step direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= ZERO;
            dir_up <= 1'b0;
        end else if (wr_cnt) begin
            cnt <= cnt_wdata;
        end else if (run) begin
            if (ld_phase) begin
                cnt <= phase_val;
            end else begin
                cnt    <= cnt_nxt;
                dir_up <= step_up;
            end
        end
    end

    // R2: free-running steps move by exactly one.
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && !ld_phase) |=> (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

    // R2: the counter always leaves zero upward.
    assert_leave_zero_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && !ld_phase && cnt == ZERO) |=> (cnt == ONE));

    // R8: frozen counter holds.
    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    // R9: a direct write lands on the next edge.
    assert_direct_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(cnt_wdata)));

    // R10: a phase load lands on the next edge.
    assert_phase_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ld_phase && !wr_cnt) |=> (cnt == $past(phase_val)));

endmodule

// File: rtl/pwmtb_aq_chan.sv
// One output of the action qualifier. It holds a writable action table and
// applies the action of the highest-priority active event each cycle.
// Event index 0 (zero) has the highest priority and index 4 the lowest.
// Assumes: event strobes are already qualified by the time-base enable.
module pwmtb_aq_chan
    import pwmtb_pkg::*;
#(
    parameter aq_cfg_t CFG_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  aq_cfg_t           cfg_wdata,
    input  logic [AQ_NEV-1:0] ev,
    output logic              out
);

    aq_cfg_t cfg;
    aq_act_e acts [AQ_NEV];
    aq_act_e sel;
    logic    out_nxt;

    // Hold the action table.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RST;
        else if (wr_cfg) cfg <= cfg_wdata;
    end

    // Map table fields onto event indices.
    always_comb begin
        acts[0] = cfg.zro;
        acts[1] = cfg.cau;
        acts[2] = cfg.cad;
        acts[3] = cfg.cbu;
        acts[4] = cfg.cbd;
    end

    // Pick the action of the highest-priority event that has one.
    always_comb begin
        sel = AQ_NONE;
        for (int i = AQ_NEV - 1; i >= 0; i--) begin
            if (ev[i] && acts[i] != AQ_NONE) sel = acts[i];
        end
    end

    // Compute the next output level from the chosen action.
    always_comb begin
        case (sel)
            AQ_CLR:  out_nxt = 1'b0;
            AQ_SET:  out_nxt = 1'b1;
            AQ_TGL:  out_nxt = ~out;
            default: out_nxt = out;
        endcase
    end

    // Register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else        out <= out_nxt;
    end

    // R7: a zero event with a set action wins over anything else.
    assert_zero_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[0] && cfg.zro == AQ_SET) |=> out);

    // R7: a zero event with a clear action wins as well.
    assert_zero_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[0] && cfg.zro == AQ_CLR) |=> !out);

    // R13: with no event the output holds.
    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> $stable(out));

endmodule

// File: rtl/pwm_updown_aq.sv
// Center-aligned PWM time base. It connects the top-value and compare
// double buffers, the up-down counter, the event decode, two action-qualified
// outputs, the sync output and the zero interrupt.
// Assumes: tb_en is shared by every copy that must start together.
module pwm_updown_aq
    import pwmtb_pkg::*;
#(
    parameter int            CW       = 16,
    parameter logic [CW-1:0] PRD_RST  = 16'd100,
    parameter logic [CW-1:0] CMPA_RST = 16'd50,
    parameter logic [CW-1:0] CMPB_RST = 16'd50,
    parameter aq_cfg_t       AQA_RST  = '{cbd: AQ_NONE, cbu: AQ_NONE, cad: AQ_NONE, cau: AQ_CLR,  zro: AQ_SET},
    parameter aq_cfg_t       AQB_RST  = '{cbd: AQ_NONE, cbu: AQ_NONE, cad: AQ_CLR,  cau: AQ_NONE, zro: AQ_SET}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tb_en,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          prd_wr,
    input  logic [CW-1:0] prd_wdata,
    input  logic          cmpa_wr,
    input  logic [CW-1:0] cmpa_wdata,
    input  logic          cmpb_wr,
    input  logic [CW-1:0] cmpb_wdata,
    input  logic          aqa_wr,
    input  logic          aqb_wr,
    input  logic [9:0]    aq_wdata,
    input  logic          phase_en,
    input  logic [CW-1:0] phase_val,
    input  logic          sync_master,
    input  logic          sync_in,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          sync_out,
    output logic          zero_irq,
    output logic [CW-1:0] cnt_val
);

    localparam int            NCMP = 2;
    localparam int            NOUT = 2;
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] CMP_RST [NCMP] = '{CMPA_RST, CMPB_RST};
    localparam aq_cfg_t       AQ_RST  [NOUT] = '{AQA_RST, AQB_RST};

    logic [CW-1:0]     cnt;
    logic              dir_up;
    logic              at_zero;
    logic              ev_zero;
    logic              ld_phase;
    logic [CW-1:0]     prd_act;
    logic              cmp_wr    [NCMP];
    logic [CW-1:0]     cmp_wdata [NCMP];
    logic [CW-1:0]     cmp_act   [NCMP];
    logic [NCMP-1:0]   ev_up;
    logic [NCMP-1:0]   ev_dn;
    logic [AQ_NEV-1:0] ev_vec;
    logic [NOUT-1:0]   aq_wr;
    logic [NOUT-1:0]   pwm;

    // Decode the shared conditions of the time base.
    always_comb begin
        at_zero  = (cnt == ZERO);
        ev_zero  = tb_en && at_zero;
        ld_phase = phase_en && sync_in;
        cmp_wr[0]    = cmpa_wr;
        cmp_wr[1]    = cmpb_wr;
        cmp_wdata[0] = cmpa_wdata;
        cmp_wdata[1] = cmpb_wdata;
        aq_wr        = {aqb_wr, aqa_wr};
    end

    // The top value is double-buffered and switches at counter zero.
    pwmtb_shadow #(.W(CW), .RST(PRD_RST)) u_prd (
        .clk(clk), .rst_n(rst_n), .wr(prd_wr), .wdata(prd_wdata),
        .load(at_zero), .active(prd_act)
    );

    pwmtb_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(tb_en), .wr_cnt(cnt_wr),
        .cnt_wdata(cnt_wdata), .ld_phase(ld_phase), .phase_val(phase_val),
        .prd_act(prd_act), .cnt(cnt), .dir_up(dir_up)
    );

    // One double buffer and one rising/falling match decode per compare.
    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        pwmtb_shadow #(.W(CW), .RST(CMP_RST[gi])) u_cmp (
            .clk(clk), .rst_n(rst_n), .wr(cmp_wr[gi]), .wdata(cmp_wdata[gi]),
            .load(at_zero), .active(cmp_act[gi])
        );
        // Qualify the match by enable and by the last step direction.
        always_comb begin
            ev_up[gi] = tb_en && (cnt == cmp_act[gi]) && dir_up;
            ev_dn[gi] = tb_en && (cnt == cmp_act[gi]) && !dir_up;
        end
    end

    // Order the events by priority: zero, A rising, A falling, B rising, B falling.
    always_comb ev_vec = {ev_dn[1], ev_up[1], ev_dn[0], ev_up[0], ev_zero};

    // One action-qualified output per channel, each with its own reset table.
    for (genvar go = 0; go < NOUT; go++) begin : g_out
        pwmtb_aq_chan #(.CFG_RST(AQ_RST[go])) u_aq (
            .clk(clk), .rst_n(rst_n), .wr_cfg(aq_wr[go]),
            .cfg_wdata(aq_cfg_t'(aq_wdata)), .ev(ev_vec), .out(pwm[go])
        );
    end

    // Register the zero interrupt and the selected sync output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_irq <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            zero_irq <= ev_zero;
            sync_out <= sync_master ? ev_zero : sync_in;
        end
    end

    assign pwm_a   = pwm[0];
    assign pwm_b   = pwm[1];
    assign cnt_val = cnt;

    // R12: an interrupt only follows an enabled cycle at counter zero.
    assert_irq_after_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        zero_irq |-> ($past(cnt) == ZERO && $past(tb_en)));

    // R11: in slave mode the sync output repeats the input one clock later.
    assert_sync_repeat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_master |=> (sync_out == $past(sync_in)));

    // R3: the working top value is steady while the counter is away from zero.
    assert_prd_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !at_zero |=> $stable(prd_act));

endmodule

// File: tb/sim_pwm_updown_aq.sv
`timescale 1ns/1ps
module sim_pwm_updown_aq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_en = 1'b0;
    logic        cnt_wr = 1'b0, prd_wr = 1'b0, cmpa_wr = 1'b0, cmpb_wr = 1'b0;
    logic        aqa_wr = 1'b0, aqb_wr = 1'b0;
    logic [15:0] cnt_wdata = '0, prd_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
    logic [9:0]  aq_wdata = '0;
    logic        phase_en = 1'b0, sync_master = 1'b1, sync_in = 1'b0;
    logic [15:0] phase_val = '0;
    logic        pwm_a, pwm_b, sync_out, zero_irq;
    logic [15:0] cnt_val;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwm_updown_aq u0 (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
        .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
        .aqa_wr(aqa_wr), .aqb_wr(aqb_wr), .aq_wdata(aq_wdata),
        .phase_en(phase_en), .phase_val(phase_val),
        .sync_master(sync_master), .sync_in(sync_in),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(sync_out),
        .zero_irq(zero_irq), .cnt_val(cnt_val)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called just after a negedge: one-cycle write strobe. kind 0 cnt,1 prd,2 cmpa,3 cmpb,4 aqa,5 aqb
    task automatic do_write(input int kind, input int val);
        case (kind)
            0: begin cnt_wdata  = 16'(val); cnt_wr  = 1'b1; end
            1: begin prd_wdata  = 16'(val); prd_wr  = 1'b1; end
            2: begin cmpa_wdata = 16'(val); cmpa_wr = 1'b1; end
            3: begin cmpb_wdata = 16'(val); cmpb_wr = 1'b1; end
            4: begin aq_wdata   = 10'(val); aqa_wr  = 1'b1; end
            default: begin aq_wdata = 10'(val); aqb_wr = 1'b1; end
        endcase
        @(negedge clk);
        cnt_wr = 0; prd_wr = 0; cmpa_wr = 0; cmpb_wr = 0; aqa_wr = 0; aqb_wr = 0;
    endtask

    // Checks one step k (1..2P) of a cycle that began with a zero event.
    task automatic check_step(input int P, input int C, input int k);
        chk("R2",  "count",   int'(cnt_val), (k <= P) ? k : 2*P - k);
        chk("R5",  "pwm_a",   int'(pwm_a),   (k <= C) ? 1 : 0);
        chk("R6",  "pwm_b",   int'(pwm_b),   (k <= 2*P - C) ? 1 : 0);
        chk("R12", "irq",     int'(zero_irq), (k == 1) ? 1 : 0);
        chk("R11", "syncout", int'(sync_out), (k == 1) ? 1 : 0);
    endtask

    // Entered at a negedge with cnt 0 and tb_en high. hook: 1 top write, 2 cmpA write, 3 freeze.
    task automatic run_periods(input int P, input int C, input int n, input int hook, input int hval);
        for (int p = 0; p < n; p++) begin
            for (int k = 1; k <= 2*P; k++) begin
                @(negedge clk);
                prd_wr = 0; cmpa_wr = 0;
                check_step(P, C, k);
                if (p == 0 && k == 3 && hook == 1) begin prd_wdata = 16'(hval); prd_wr = 1'b1; end
                if (p == 0 && k == 3 && hook == 2) begin cmpa_wdata = 16'(hval); cmpa_wr = 1'b1; end
                if (p == 0 && k == 5 && hook == 3) begin
                    tb_en = 1'b0;
                    for (int f = 0; f < 3; f++) begin
                        @(negedge clk);
                        chk("R8", "frozen count", int'(cnt_val), 5);
                        chk("R8", "frozen pwm_a", int'(pwm_a), (5 <= C) ? 1 : 0);
                        chk("R8", "frozen irq",   int'(zero_irq), 0);
                    end
                    tb_en = 1'b1;
                end
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset count", int'(cnt_val), 0);
        chk("R1", "reset pwm_a", int'(pwm_a), 0);
        chk("R1", "reset pwm_b", int'(pwm_b), 0);
        chk("R1", "reset irq",   int'(zero_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_setup_frozen;
        do_write(1, 8);
        do_write(2, 3);
        do_write(3, 5);
        repeat (3) @(negedge clk);
        chk("R8", "idle count", int'(cnt_val), 0);
        chk("R8", "idle pwm_a", int'(pwm_a), 0);
        chk("R8", "idle irq",   int'(zero_irq), 0);
    endtask

    task automatic t_basic;
        tb_en = 1'b1;
        run_periods(8, 3, 2, 0, 0);
    endtask

    task automatic t_period_shadow;   // R3
        run_periods(8, 3, 1, 1, 6);
        run_periods(6, 3, 1, 0, 0);
    endtask

    task automatic t_cmp_shadow;      // R4
        run_periods(6, 3, 1, 2, 2);
        run_periods(6, 2, 1, 0, 0);
    endtask

    task automatic t_freeze_mid;      // R8
        run_periods(6, 2, 1, 3, 0);
    endtask

    task automatic t_direct_write;    // R9
        tb_en = 1'b0;
        do_write(0, 4);
        chk("R9", "frozen write", int'(cnt_val), 4);
        do_write(0, 0);
        chk("R9", "write zero", int'(cnt_val), 0);
        do_write(1, 8);
        @(negedge clk);
        tb_en = 1'b1;
        run_periods(8, 2, 1, 0, 0);
    endtask

    task automatic t_phase;           // R10
        @(negedge clk); chk("R10", "pre count", int'(cnt_val), 1);
        @(negedge clk); chk("R10", "pre count", int'(cnt_val), 2);
        phase_en = 1'b1; phase_val = 16'd6; sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        chk("R10", "phase load", int'(cnt_val), 6);
        @(negedge clk); chk("R10", "after load", int'(cnt_val), 7);
        phase_en = 1'b0; sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        chk("R10", "sync ignored", int'(cnt_val), 8);
        tb_en = 1'b0;
        do_write(0, 0);
        @(negedge clk);
        tb_en = 1'b1;
        run_periods(8, 2, 1, 0, 0);
    endtask

    task automatic t_sync_slave;      // R11
        tb_en = 1'b0;
        sync_master = 1'b0; sync_in = 1'b1;
        @(negedge clk);
        chk("R11", "slave high", int'(sync_out), 1);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R11", "slave low", int'(sync_out), 0);
        sync_master = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_zero_priority;   // R7
        do_write(2, 0);
        @(negedge clk);
        tb_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int k = 1; k <= 16; k++) begin
                @(negedge clk);
                chk("R7", "pwm_a high", int'(pwm_a), 1);
                chk("R7", "pwm_b high", int'(pwm_b), 1);
                chk("R2", "count", int'(cnt_val), (k <= 8) ? k : 16 - k);
                if (p == 1 && k == 16) tb_en = 1'b0;
            end
        end
    endtask

    task automatic t_toggle;          // R13: B table = compare B rising toggle (0x0C0)
        logic b5, b6;
        b6 = pwm_b;
        do_write(2, 2);
        do_write(5, 10'h0C0);
        @(negedge clk);
        tb_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int k = 1; k <= 16; k++) begin
                @(negedge clk);
                if (k == 1) chk("R13", "no zero action on B", int'(pwm_b), int'(b6));
                if (k == 5) b5 = pwm_b;
                if (k == 6) begin
                    b6 = pwm_b;
                    chk("R13", "toggle at compare B", int'(b6), int'(!b5));
                end
                chk("R13", "pwm_a unaffected", int'(pwm_a), (k <= 2) ? 1 : 0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_setup_frozen();
        t_basic();
        t_period_shadow();
        t_cmp_shadow();
        t_freeze_mid();
        t_direct_write();
        t_phase();
        t_sync_slave();
        t_zero_priority();
        t_toggle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule